// File: doc/BRIEF.md
# Time Base, Watchdog and Tone Generator

This block derives three slow outputs from a system clock enable of about 32 kHz. The first is a periodic time-base square wave with eight selectable rates. The second is a watchdog whose time-out latches onto an active-low interrupt line. The third is a complementary buzzer tone pair that can run at two pitches.

A single binary divider chain produces all the time-base rates. A 2-bit watchdog stage counts complete periods of the selected rate and raises a sticky flag on its fourth count. A separate small counter produces the tone.

Control arrives from an upstream command decoder as single-cycle strobes. The strobes enable, disable and clear the timer and the watchdog, enable and mask the interrupt, load a rate and pick the tone. Each strobe is sampled on the rising clock edge where it is high. All state sits in the `clk_i` domain, and `tick_i` marks each system tick.

Top module: `timebase_wdt_tone`

## Requirements
- R1: After reset `tb_o`=0, `irq_no`=1, `bz_o`=0 and `bz_no`=0. The timer, watchdog and interrupt are disabled, the tone is off and the rate code is 0.
- R2: While the timer is enabled, `tb_o` is a square wave with a period of 2^(15-k) ticks. Here k is the 3-bit rate code loaded by `rate_set_i`: code 0 gives the slowest rate (1 Hz at 32768 Hz) and code 7 the fastest (128 Hz, 256 ticks).
- R3: While the timer is disabled, `tb_o` is 0 and the time-base wave does not reach `irq_no`.
- R4: The divider, the watchdog stage and the tone counter advance only on clock edges where `tick_i`=1.
- R5: Suppose the divider starts at zero and the watchdog stage has been cleared. The watchdog flag then sets on the edge that ends the fourth full period of the selected rate. For code 7 that edge is 1024 ticks after the enable takes effect.
- R6: `irq_no` is low exactly when the interrupt is enabled and either the watchdog flag is set or `tb_o` is high.
- R7: The watchdog flag stays set until a `wdt_clr_i` or `irq_dis_i` strobe. Disabling the watchdog does not clear it.
- R8: A `tmr_clr_i` strobe zeroes the divider. `tb_o` then first rises 2^(14-k) ticks after the clear edge.
- R9: `tone_hi_i` selects a tone that is high for 4 ticks in every 8. `tone_lo_i` selects a tone that is high for 8 ticks in every 16. Either strobe restarts the tone phase low, and `bz_no` is the complement of `bz_o` while the tone runs.
- R10: After `tone_off_i` both `bz_o` and `bz_no` are held low.
- R11: When an enable strobe and its matching disable strobe arrive in the same cycle, the disable wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | System tick enable |
| tmr_en_i | input | 1 | Timer enable strobe |
| tmr_dis_i | input | 1 | Timer disable strobe |
| tmr_clr_i | input | 1 | Divider clear strobe |
| wdt_en_i | input | 1 | Watchdog enable strobe |
| wdt_dis_i | input | 1 | Watchdog disable strobe |
| wdt_clr_i | input | 1 | Watchdog stage and flag clear strobe |
| irq_en_i | input | 1 | Interrupt output enable strobe |
| irq_dis_i | input | 1 | Interrupt output disable strobe, also clears the flag |
| rate_set_i | input | 1 | Load `rate_i` as the rate code |
| rate_i | input | 3 | Rate code, 0 slowest to 7 fastest |
| tone_hi_i | input | 1 | Select the higher tone |
| tone_lo_i | input | 1 | Select the lower tone |
| tone_off_i | input | 1 | Tone off strobe |
| tb_o | output | 1 | Time-base square wave |
| irq_no | output | 1 | Interrupt, active low |
| bz_o | output | 1 | Buzzer tone, true phase |
| bz_no | output | 1 | Buzzer tone, complement phase |

## Verification
A corrupt divider count shows up at `tb_o` as a wrong period or wrong phase, within one period of the selected rate. The bench therefore measures full periods edge to edge and times the first rise after a clear to the exact tick. A wrong watchdog stage moves the fall of `irq_no` away from tick 1024. The bench pins that edge to a single cycle and then checks that the flag persists across a watchdog disable. Tone faults appear within 16 ticks as a wrong high time or as the pair failing to be complementary.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  typedef enum logic [1:0] {
    TONE_OFF = 2'd0,
    TONE_HI  = 2'd1,
    TONE_LO  = 2'd2
  } tone_mode_e;
endpackage

// File: rtl/tbw_divider.sv
module tbw_divider #(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned POST_W = 7,
  parameter int unsigned SEL_W  = 3,
  localparam int unsigned CHAIN_W  = PRE_W + POST_W,
  localparam int unsigned CHAIN_IW = $clog2(CHAIN_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               run_i,
  input  logic               clr_i,
  input  logic [SEL_W-1:0]   rate_i,
  output logic               wave_o,
  output logic               period_end_o,
  output logic [CHAIN_W-1:0] chain_o
);
  logic [CHAIN_W-1:0]  chain_q;
  logic [CHAIN_W-1:0]  mask;
  logic [CHAIN_IW-1:0] idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              chain_q <= '0;
    else if (clr_i)           chain_q <= '0;
    else if (tick_i && run_i) chain_q <= chain_q + 1'b1;
  end

  // slowest rate taps the top bit; each code step halves the period
  always_comb begin
    idx  = CHAIN_IW'(CHAIN_W - 1) - CHAIN_IW'(rate_i);
    mask = {CHAIN_W{1'b1}} >> rate_i;
  end

  assign wave_o       = chain_q[idx];
  assign period_end_o = tick_i && run_i && !clr_i && ((chain_q & mask) == mask);
  assign chain_o      = chain_q;
endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog #(
  parameter int unsigned WDT_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic period_end_i,
  input  logic stage_clr_i,
  input  logic flag_clr_i,
  output logic flag_o
);
  logic [WDT_W-1:0] stage_q;
  logic             flag_q;
  logic             step;

  assign step = en_i && period_end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          stage_q <= '0;
    else if (stage_clr_i) stage_q <= '0;
    else if (step)        stage_q <= stage_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        flag_q <= 1'b0;
    else if (flag_clr_i)                flag_q <= 1'b0;
    else if (step && (&stage_q) && !stage_clr_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tbw_tone.sv
module tbw_tone
  import tbw_pkg::*;
#(
  parameter int unsigned HI_SH = 2,
  parameter int unsigned LO_SH = 3,
  localparam int unsigned CNT_W = ((HI_SH > LO_SH) ? HI_SH : LO_SH) + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  tone_mode_e mode_i,
  input  logic       restart_i,
  output logic       bz_o,
  output logic       bz_no
);
  logic [CNT_W-1:0] cnt_q;
  logic             on;
  logic             wave;

  assign on = (mode_i != TONE_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (restart_i)    cnt_q <= '0;
    else if (tick_i && on) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    unique case (mode_i)
      TONE_HI: wave = cnt_q[HI_SH];
      TONE_LO: wave = cnt_q[LO_SH];
      default: wave = 1'b0;
    endcase
  end

  assign bz_o  = on && wave;
  assign bz_no = on && !wave;
endmodule

// File: rtl/timebase_wdt_tone.sv
module timebase_wdt_tone
  import tbw_pkg::*;
#(
  parameter int unsigned PRE_W      = 8,
  parameter int unsigned POST_W     = 7,
  parameter int unsigned WDT_W      = 2,
  parameter int unsigned TONE_HI_SH = 2,
  parameter int unsigned TONE_LO_SH = 3,
  localparam int unsigned SEL_W   = $clog2(POST_W + 1),
  localparam int unsigned CHAIN_W = PRE_W + POST_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             tmr_en_i,
  input  logic             tmr_dis_i,
  input  logic             tmr_clr_i,
  input  logic             wdt_en_i,
  input  logic             wdt_dis_i,
  input  logic             wdt_clr_i,
  input  logic             irq_en_i,
  input  logic             irq_dis_i,
  input  logic             rate_set_i,
  input  logic [SEL_W-1:0] rate_i,
  input  logic             tone_hi_i,
  input  logic             tone_lo_i,
  input  logic             tone_off_i,
  output logic             tb_o,
  output logic             irq_no,
  output logic             bz_o,
  output logic             bz_no
);
  logic               tmr_en_q, wdt_en_q, irq_en_q;
  logic [SEL_W-1:0]   rate_q;
  tone_mode_e         tone_q;
  logic               wave, period_end, wdt_flag;
  logic [CHAIN_W-1:0] chain;

  // disable strobes take priority over enable strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_en_q <= 1'b0;
      wdt_en_q <= 1'b0;
      irq_en_q <= 1'b0;
      rate_q   <= '0;
      tone_q   <= TONE_OFF;
    end else begin
      if (tmr_dis_i)     tmr_en_q <= 1'b0;
      else if (tmr_en_i) tmr_en_q <= 1'b1;
      if (wdt_dis_i)     wdt_en_q <= 1'b0;
      else if (wdt_en_i) wdt_en_q <= 1'b1;
      if (irq_dis_i)     irq_en_q <= 1'b0;
      else if (irq_en_i) irq_en_q <= 1'b1;
      if (rate_set_i)    rate_q   <= rate_i;
      if (tone_off_i)     tone_q <= TONE_OFF;
      else if (tone_hi_i) tone_q <= TONE_HI;
      else if (tone_lo_i) tone_q <= TONE_LO;
    end
  end

  tbw_divider #(
    .PRE_W (PRE_W),
    .POST_W(POST_W),
    .SEL_W (SEL_W)
  ) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .run_i       (tmr_en_q || wdt_en_q),
    .clr_i       (tmr_clr_i),
    .rate_i      (rate_q),
    .wave_o      (wave),
    .period_end_o(period_end),
    .chain_o     (chain)
  );

  tbw_watchdog #(
    .WDT_W(WDT_W)
  ) u_wdt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (wdt_en_q),
    .period_end_i(period_end),
    .stage_clr_i (wdt_clr_i),
    .flag_clr_i  (wdt_clr_i || irq_dis_i),
    .flag_o      (wdt_flag)
  );

  tbw_tone #(
    .HI_SH(TONE_HI_SH),
    .LO_SH(TONE_LO_SH)
  ) u_tone (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .mode_i   (tone_q),
    .restart_i((tone_hi_i || tone_lo_i) && !tone_off_i),
    .bz_o     (bz_o),
    .bz_no    (bz_no)
  );

  assign tb_o   = tmr_en_q && wave;
  assign irq_no = !(irq_en_q && (wdt_flag || tb_o));
endmodule

module timebase_wdt_tone_chk #(
  parameter int unsigned CHAIN_W = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               tmr_dis_i,
  input logic               tmr_clr_i,
  input logic               wdt_clr_i,
  input logic               irq_dis_i,
  input logic               tone_off_i,
  input logic               tb_o,
  input logic               irq_no,
  input logic               bz_o,
  input logic               bz_no,
  input logic               flag_i,
  input logic [CHAIN_W-1:0] chain_i
);
  p_bz_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bz_o && bz_no));

  p_tone_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tone_off_i |=> (!bz_o && !bz_no));

  p_tick_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !tmr_clr_i) |=> $stable(chain_i));

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !wdt_clr_i && !irq_dis_i) |=> flag_i);

  p_flag_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_clr_i || irq_dis_i) |=> !flag_i);

  p_irq_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_dis_i |=> irq_no);

  p_tmr_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_dis_i |=> !tb_o);
endmodule

bind timebase_wdt_tone timebase_wdt_tone_chk #(.CHAIN_W(CHAIN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .tmr_dis_i (tmr_dis_i),
  .tmr_clr_i (tmr_clr_i),
  .wdt_clr_i (wdt_clr_i),
  .irq_dis_i (irq_dis_i),
  .tone_off_i(tone_off_i),
  .tb_o      (tb_o),
  .irq_no    (irq_no),
  .bz_o      (bz_o),
  .bz_no     (bz_no),
  .flag_i    (wdt_flag),
  .chain_i   (chain)
);

// File: tb/timebase_wdt_tone_tb.sv
module timebase_wdt_tone_tb;
  localparam int C_TEN = 0, C_TDIS = 1, C_TCLR = 2, C_WEN = 3, C_WDIS = 4, C_WCLR = 5;
  localparam int C_IEN = 6, C_IDIS = 7, C_RATE = 8, C_THI = 9, C_TLO = 10, C_TOFF = 11;
  localparam int K_TB = 0, K_BZ = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic [11:0] cmd = '0;
  logic [2:0]  rate = '0;
  logic        tb, irq_n, bz, bz_n;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    string req;
    int    kind;
    int    exp;
  } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  timebase_wdt_tone u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .tmr_en_i  (cmd[C_TEN]),
    .tmr_dis_i (cmd[C_TDIS]),
    .tmr_clr_i (cmd[C_TCLR]),
    .wdt_en_i  (cmd[C_WEN]),
    .wdt_dis_i (cmd[C_WDIS]),
    .wdt_clr_i (cmd[C_WCLR]),
    .irq_en_i  (cmd[C_IEN]),
    .irq_dis_i (cmd[C_IDIS]),
    .rate_set_i(cmd[C_RATE]),
    .rate_i    (rate),
    .tone_hi_i (cmd[C_THI]),
    .tone_lo_i (cmd[C_TLO]),
    .tone_off_i(cmd[C_TOFF]),
    .tb_o      (tb),
    .irq_no    (irq_n),
    .bz_o      (bz),
    .bz_no     (bz_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // strobe a command mask for one cycle; returns at the negedge after it took effect
  task automatic send(input logic [11:0] m);
    @(negedge clk) cmd = m;
    @(negedge clk) cmd = '0;
  endtask

  task automatic push_exp(input string req, input int kind, input int exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    exp_q.push_back(it);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic hold_check(input string req, input int cycles, input logic want_tb, input logic want_irq);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tb !== want_tb || irq_n !== want_irq) bad++;
    end
    check(req, bad, 0);
  endtask

  // monitor: measures what the head of the queue asks for and compares
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        item_t it;
        int n;
        int cbad;
        it = exp_q[0];
        n = 0;
        cbad = 0;
        if (it.kind == K_TB) begin
          while (tb !== 1'b0) @(negedge clk);
          while (tb !== 1'b1) @(negedge clk);
          do begin @(negedge clk); n++; end while (tb !== 1'b0);
          while (tb !== 1'b1) begin @(negedge clk); n++; end
          check(it.req, n, it.exp);
        end else begin
          while (bz !== 1'b0) @(negedge clk);
          while (bz !== 1'b1) @(negedge clk);
          while (bz === 1'b1) begin
            if (bz_n !== 1'b0) cbad++;
            @(negedge clk); n++;
          end
          if (bz_n !== 1'b1) cbad++;
          check(it.req, n, it.exp);
          check({it.req, " complement"}, cbad, 0);
        end
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    int bad;
    logic prev;
    repeat (3) @(negedge clk);
    check("R1 tb_o", int'(tb), 0);
    check("R1 irq_no", int'(irq_n), 1);
    check("R1 bz_o", int'(bz), 0);
    check("R1 bz_no", int'(bz_n), 0);
    @(negedge clk) rst_n = 1'b1;
    hold_check("R1 R3 idle after reset", 300, 1'b0, 1'b1);

    // time base at the fastest and next rates, irq follows the wave
    rate = 3'd7;
    send(12'(1 << C_RATE) | 12'(1 << C_TEN) | 12'(1 << C_IEN));
    push_exp("R2 period code 7", K_TB, 256);
    bad = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (irq_n !== !tb) bad++;
    end
    check("R6 irq_no tracks tb_o", bad, 0);
    rate = 3'd6;
    send(12'(1 << C_RATE));
    push_exp("R2 period code 6", K_TB, 512);

    // tick gating
    @(negedge clk) tick = 1'b0;
    prev = tb;
    bad = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (tb !== prev) bad++;
    end
    check("R4 tb_o frozen without tick", bad, 0);
    tick = 1'b1;

    // divider clear: first rise 128 ticks after the clear edge (counted from negedge 1)
    rate = 3'd7;
    send(12'(1 << C_RATE));
    send(12'(1 << C_TCLR));
    n = 1;
    check("R8 tb_o low after clear", int'(tb), 0);
    while (tb !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
    check("R8 first rise after clear", n, 128 + 1);

    // timer off
    send(12'(1 << C_TDIS));
    hold_check("R3 timer disabled", 300, 1'b0, 1'b1);
    send(12'(1 << C_TEN) | 12'(1 << C_TDIS));
    hold_check("R11 disable wins", 600, 1'b0, 1'b1);

    // watchdog at code 7: flag at tick 1024, irq enabled, timer off
    send(12'(1 << C_TCLR) | 12'(1 << C_WCLR));
    send(12'(1 << C_WEN));
    n = 1;
    bad = 0;
    while (n < 1024) begin
      if (irq_n !== 1'b1) bad++;
      @(negedge clk); n++;
    end
    check("R5 no early time-out", bad, 0);
    check("R5 irq_no high at tick 1024", int'(irq_n), 1);
    @(negedge clk);
    check("R5 irq_no low at tick 1025", int'(irq_n), 0);
    repeat (400) @(negedge clk);
    check("R7 flag held", int'(irq_n), 0);
    send(12'(1 << C_WCLR));
    check("R7 wdt clear releases irq", int'(irq_n), 1);
    repeat (1100) @(negedge clk);
    check("R5 time-out again", int'(irq_n), 0);
    send(12'(1 << C_WDIS));
    repeat (50) @(negedge clk);
    check("R7 wdt disable keeps flag", int'(irq_n), 0);
    send(12'(1 << C_IDIS));
    check("R6 irq masked", int'(irq_n), 1);
    send(12'(1 << C_IEN));
    hold_check("R7 irq disable cleared flag", 1200, 1'b0, 1'b1);

    // tone
    send(12'(1 << C_THI));
    check("R9 phase restarts low", int'(bz), 0);
    push_exp("R9 high tone high time", K_BZ, 4);
    send(12'(1 << C_TLO));
    check("R9 phase restarts low lo", int'(bz), 0);
    push_exp("R9 low tone high time", K_BZ, 8);
    send(12'(1 << C_TOFF));
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bz !== 1'b0 || bz_n !== 1'b0) bad++;
    end
    check("R10 tone off both low", bad, 0);

    // slowest rate
    rate = 3'd0;
    send(12'(1 << C_RATE) | 12'(1 << C_TEN));
    push_exp("R2 period code 0", K_TB, 32768);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule